// File: doc/BRIEF.md
# Double-Precision to Unsigned Integer Converter

This block takes one 64-bit IEEE-754 double-precision operand and turns it into an unsigned integer that is either 32 or 64 bits wide, zero-extended to a 64-bit result. The operand is aligned against a fixed binary point and rounded in one of four modes. That mode comes from one of two places. A global 2-bit field is the default. An embedded 2-bit field takes its place only when the operand came from a register and the override enable is set. Values that cannot be represented are reported on an invalid flag. Rounding loss is reported on a precision flag.

A single registered stage sits between the operand and the result. A two-state machine tracks whether the output register holds a fresh conversion. The states are `ST_IDLE` (no result this cycle) and `ST_OUT` (result valid). `T_ACCEPT` moves the machine from `ST_IDLE` to `ST_OUT` on `in_vld`. `T_STREAM` keeps it in `ST_OUT` on back-to-back operands. `T_DRAIN` returns it from `ST_OUT` to `ST_IDLE` when no operand arrives. `T_WAIT` keeps it in `ST_IDLE`.

When the invalid exception is unmasked, the block raises a trap. The result register then keeps its previous contents.

Top module: `dbl2uint_cvt`

## Requirements
- R1: `out_vld` is high in exactly the cycle after a cycle with `in_vld` high. While `out_vld` is low, `out_inv`, `out_pe` and `out_trap` are low. After reset, `out_res` is zero and `out_vld` is low.
- R2: The destination is 64 bits wide only when `in_wide` and `in_mode64` are both 1. Otherwise it is 32 bits, and `out_res[63:32]` is zero.
- R3: With `in_mode64` = 0, the value of `in_wide` has no effect on any output.
- R4: The embedded field `in_emb_rc` selects the rounding mode only when `in_op_reg` and `in_emb_en` are both 1. In every other case `in_glb_rc` selects it.
- R5: The rounding field encodes four modes: 00 is nearest with ties to even, 01 is toward minus infinity, 10 is toward plus infinity, 11 is toward zero. A conversion that loses nonzero fraction bits sets `out_pe`.
- R6: A positive value whose rounded result exceeds 2^w−1 sets `out_inv`. When `in_inv_mask` = 1, the result is 2^w−1 (all ones in the w-bit destination).
- R7: A NaN of either sign, or an infinity of either sign, sets `out_inv`.
- R8: A negative value that rounds to zero returns 0 with `out_inv` low, and sets `out_pe` if the value was nonzero. A negative value that rounds to a nonzero magnitude sets `out_inv`.
- R9: Positive and negative zero convert to 0 with no flags. A denormal converts to 0 or 1 according to the mode and sets `out_pe`.
- R10: `out_inv` and `out_pe` are never both high. When `out_inv` is high and `in_inv_mask` was 0, `out_trap` is high and `out_res` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operand valid |
| in_op | input | 64 | Double-precision operand |
| in_wide | input | 1 | Requests a 64-bit destination |
| in_mode64 | input | 1 | 64-bit mode active |
| in_glb_rc | input | 2 | Global rounding-control field |
| in_emb_rc | input | 2 | Embedded rounding-control field |
| in_emb_en | input | 1 | Embedded rounding override enable |
| in_op_reg | input | 1 | Operand comes from a register |
| in_inv_mask | input | 1 | Invalid exception masked when 1 |
| out_vld | output | 1 | Result valid |
| out_res | output | 64 | Zero-extended unsigned result |
| out_inv | output | 1 | Invalid flag |
| out_pe | output | 1 | Precision (inexact) flag |
| out_trap | output | 1 | Unmasked invalid trap |

## Verification
The hardest situations to reach are the rounding carries at the exact top of a destination range. One case is a value of 2^32−0.5: it fits as 2^32−1 under truncation but overflows under ties-to-even. The other is the largest double below 2^64. The stimulus drives these hand-encoded operands under several modes and both widths, so a single operand lands on each side of the overflow boundary. The trap-hold case is reached by first converting a known value and then sending an unmasked NaN. This shows that the earlier result survives.

// File: rtl/d2u_pkg.sv
package d2u_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } st_e;

    typedef struct packed {
        logic [63:0] val;
        logic        inv;
        logic        pe;
    } cvt_res_t;

endpackage

// File: rtl/d2u_rmode_sel.sv
module d2u_rmode_sel
    import d2u_pkg::*;
(
    input  logic [1:0] glb_rc,
    input  logic [1:0] emb_rc,
    input  logic       emb_en,
    input  logic       op_reg,
    output rmode_e     rm
);
    always_comb begin
        if (op_reg && emb_en) rm = rmode_e'(emb_rc);
        else                  rm = rmode_e'(glb_rc);
    end
endmodule

// File: rtl/d2u_align.sv
module d2u_align #(
    parameter int unsigned EXP_W  = 11,
    parameter int unsigned FRAC_W = 52,
    parameter int unsigned OUT_W  = 64,
    localparam int unsigned FP_W  = 1 + EXP_W + FRAC_W
) (
    input  logic [FP_W-1:0]  op,
    output logic             sign,
    output logic             special,
    output logic             big,
    output logic [OUT_W-1:0] int_part,
    output logic             rnd,
    output logic             stk
);
    localparam int unsigned MAN_W = FRAC_W + 1;
    localparam int unsigned EXT_W = 2 * OUT_W;
    localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W:0] TOP_E   = (EXP_W+1)'(BIAS + OUT_W - 1);
    localparam logic [EXP_W:0] EXT_LIM = (EXP_W+1)'(EXT_W);

    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;
    logic [MAN_W-1:0]  m;
    logic [EXP_W:0]    e_eff;
    logic [EXP_W:0]    sh;
    logic [EXT_W-1:0]  ext;
    logic [EXT_W-1:0]  shd;
    logic              lost;

    assign sign    = op[FP_W-1];
    assign e       = op[FRAC_W +: EXP_W];
    assign f       = op[FRAC_W-1:0];
    assign m       = {|e, f};
    assign e_eff   = (e == '0) ? (EXP_W+1)'(1) : {1'b0, e};
    assign special = &e;
    assign big     = e_eff > TOP_E;
    assign sh      = TOP_E - e_eff;
    assign ext     = {m, {(EXT_W-MAN_W){1'b0}}};

    always_comb begin
        if (big) begin
            shd  = '0;
            lost = 1'b0;
        end else if (sh >= EXT_LIM) begin
            shd  = '0;
            lost = |m;
        end else begin
            shd  = ext >> sh;
            lost = 1'b0;
        end
    end

    assign int_part = shd[EXT_W-1 -: OUT_W];
    assign rnd      = shd[OUT_W-1];
    assign stk      = (|shd[OUT_W-2:0]) | lost;
endmodule

// File: rtl/d2u_round.sv
module d2u_round
    import d2u_pkg::*;
#(
    parameter int unsigned OUT_W    = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic             sign,
    input  logic             special,
    input  logic             big,
    input  logic [OUT_W-1:0] int_part,
    input  logic             rnd,
    input  logic             stk,
    input  rmode_e           rm,
    input  logic             wide,
    output cvt_res_t         res
);
    logic             inexact;
    logic             inc;
    logic [OUT_W:0]   sum;
    logic             ovf;
    logic             inv;
    logic [OUT_W-1:0] sat;

    assign inexact = rnd | stk;

    always_comb begin
        unique case (rm)
            RM_NEAR: inc = rnd & (stk | int_part[0]);
            RM_DOWN: inc = sign & inexact;
            RM_UP:   inc = ~sign & inexact;
            RM_ZERO: inc = 1'b0;
            default: inc = 1'b0;
        endcase
    end

    assign sum = {1'b0, int_part} + (OUT_W+1)'(inc);
    assign ovf = wide ? sum[OUT_W] : |sum[OUT_W:NARROW_W];
    assign inv = special | big | (sign ? (sum != '0) : ovf);
    assign sat = wide ? {OUT_W{1'b1}}
                      : {{(OUT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    always_comb begin
        res.inv = inv;
        res.pe  = ~inv & inexact;
        if (inv)       res.val = 64'(sat);
        else if (sign) res.val = '0;
        else           res.val = 64'(sum[OUT_W-1:0]);
    end
endmodule

// File: rtl/dbl2uint_cvt.sv
module dbl2uint_cvt
    import d2u_pkg::*;
#(
    parameter int unsigned EXP_W    = 11,
    parameter int unsigned FRAC_W   = 52,
    parameter int unsigned NARROW_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [63:0] in_op,
    input  logic        in_wide,
    input  logic        in_mode64,
    input  logic [1:0]  in_glb_rc,
    input  logic [1:0]  in_emb_rc,
    input  logic        in_emb_en,
    input  logic        in_op_reg,
    input  logic        in_inv_mask,
    output logic        out_vld,
    output logic [63:0] out_res,
    output logic        out_inv,
    output logic        out_pe,
    output logic        out_trap
);
    localparam int unsigned OUT_W = 1 + EXP_W + FRAC_W;

    st_e              state, state_nx;
    rmode_e           rm;
    logic             wide;
    logic             sign, special, big, rnd, stk;
    logic [OUT_W-1:0] int_part;
    cvt_res_t         cres;
    logic             trap_nx;

    assign wide = in_wide & in_mode64;

    d2u_rmode_sel i_rsel (
        .glb_rc (in_glb_rc),
        .emb_rc (in_emb_rc),
        .emb_en (in_emb_en),
        .op_reg (in_op_reg),
        .rm     (rm)
    );

    d2u_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) i_align (
        .op       (in_op),
        .sign     (sign),
        .special  (special),
        .big      (big),
        .int_part (int_part),
        .rnd      (rnd),
        .stk      (stk)
    );

    d2u_round #(.OUT_W(OUT_W), .NARROW_W(NARROW_W)) i_round (
        .sign     (sign),
        .special  (special),
        .big      (big),
        .int_part (int_part),
        .rnd      (rnd),
        .stk      (stk),
        .rm       (rm),
        .wide     (wide),
        .res      (cres)
    );

    assign trap_nx = cres.inv & ~in_inv_mask;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: T_ACCEPT, T_WAIT, T_STREAM, T_DRAIN
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = in_vld ? ST_OUT : ST_IDLE;
            ST_OUT:  state_nx = in_vld ? ST_OUT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_res  <= '0;
            out_inv  <= 1'b0;
            out_pe   <= 1'b0;
            out_trap <= 1'b0;
        end else if (in_vld) begin
            out_inv  <= cres.inv;
            out_pe   <= cres.pe;
            out_trap <= trap_nx;
            if (!trap_nx) out_res <= cres.val;
        end else begin
            out_inv  <= 1'b0;
            out_pe   <= 1'b0;
            out_trap <= 1'b0;
        end
    end

    assign out_vld = (state == ST_OUT);
endmodule

// File: rtl/d2u_cvt_chk.sv
module d2u_cvt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic [63:0] in_op,
    input logic        in_wide,
    input logic        in_mode64,
    input logic        in_inv_mask,
    input logic        out_vld,
    input logic [63:0] out_res,
    input logic        out_inv,
    input logic        out_pe,
    input logic        out_trap
);
    a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    a_r1_vld_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    a_r1_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (!out_inv && !out_pe && !out_trap));
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_trap && $past(!(in_wide && in_mode64)))
            |-> (out_res[63:32] == 32'h0));
    a_r6_wide_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_inv && !out_trap && $past(in_wide && in_mode64))
            |-> (out_res == 64'hFFFF_FFFF_FFFF_FFFF));
    a_r7_special_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (in_op[62:52] == 11'h7FF)) |=> out_inv);
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_inv && out_pe));
    a_r10_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_inv && $stable(out_res)));
    a_r10_masked_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && in_inv_mask) |=> !out_trap);
endmodule

bind dbl2uint_cvt d2u_cvt_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .in_op       (in_op),
    .in_wide     (in_wide),
    .in_mode64   (in_mode64),
    .in_inv_mask (in_inv_mask),
    .out_vld     (out_vld),
    .out_res     (out_res),
    .out_inv     (out_inv),
    .out_pe      (out_pe),
    .out_trap    (out_trap)
);

// File: tb/test_dbl2uint_cvt.sv
module test_dbl2uint_cvt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [63:0] in_op = '0;
    logic        in_wide = 1'b0;
    logic        in_mode64 = 1'b0;
    logic [1:0]  in_glb_rc = 2'b00;
    logic [1:0]  in_emb_rc = 2'b00;
    logic        in_emb_en = 1'b0;
    logic        in_op_reg = 1'b0;
    logic        in_inv_mask = 1'b1;
    logic        out_vld;
    logic [63:0] out_res;
    logic        out_inv, out_pe, out_trap;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [1:0] NEAR = 2'b00, DOWN = 2'b01, UP = 2'b10, ZERO = 2'b11;
    localparam logic [63:0] ONES32 = 64'h0000_0000_FFFF_FFFF;
    localparam logic [63:0] ONES64 = 64'hFFFF_FFFF_FFFF_FFFF;

    always #5 clk = ~clk;

    dbl2uint_cvt i_dbl2uint_cvt (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .in_wide(in_wide), .in_mode64(in_mode64), .in_glb_rc(in_glb_rc),
        .in_emb_rc(in_emb_rc), .in_emb_en(in_emb_en), .in_op_reg(in_op_reg),
        .in_inv_mask(in_inv_mask), .out_vld(out_vld), .out_res(out_res),
        .out_inv(out_inv), .out_pe(out_pe), .out_trap(out_trap)
    );

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic conv(logic [63:0] op, logic wide, logic m64, logic [1:0] grc,
                        logic [1:0] erc, logic een, logic isreg, logic mask);
        @(negedge clk);
        in_op = op; in_wide = wide; in_mode64 = m64; in_glb_rc = grc;
        in_emb_rc = erc; in_emb_en = een; in_op_reg = isreg; in_inv_mask = mask;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic expect_out(string req, logic [63:0] res, logic inv, logic pe, logic trap);
        chk(req, "vld",  64'(out_vld), 64'd1);
        chk(req, "res",  out_res, res);
        chk(req, "inv",  64'(out_inv), 64'(inv));
        chk(req, "pe",   64'(out_pe), 64'(pe));
        chk(req, "trap", 64'(out_trap), 64'(trap));
    endtask

    task automatic t_reset;
        chk("R1", "reset vld", 64'(out_vld), 64'd0);
        chk("R1", "reset res", out_res, 64'd0);
        chk("R1", "reset flags", {61'd0, out_inv, out_pe, out_trap}, 64'd0);
    endtask

    task automatic t_pipeline;
        conv(64'h3FF0_0000_0000_0000, 1'b0, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R1", 64'd1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R1", "vld drop", 64'(out_vld), 64'd0);
        chk("R1", "res kept", out_res, 64'd1);
    endtask

    task automatic t_round_modes;
        conv(64'h4004_0000_0000_0000, 1'b0, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R5 2.5 near", 64'd2, 1'b0, 1'b1, 1'b0);
        conv(64'h4004_0000_0000_0000, 1'b0, 1'b0, DOWN, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R5 2.5 down", 64'd2, 1'b0, 1'b1, 1'b0);
        conv(64'h4004_0000_0000_0000, 1'b0, 1'b0, UP, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R5 2.5 up", 64'd3, 1'b0, 1'b1, 1'b0);
        conv(64'h4004_0000_0000_0000, 1'b0, 1'b0, ZERO, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R5 2.5 zero", 64'd2, 1'b0, 1'b1, 1'b0);
        conv(64'h400C_0000_0000_0000, 1'b0, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R5 3.5 near", 64'd4, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_rmode_select;
        conv(64'h4004_0000_0000_0000, 1'b0, 1'b0, ZERO, UP, 1'b1, 1'b1, 1'b1);
        expect_out("R4 emb used", 64'd3, 1'b0, 1'b1, 1'b0);
        conv(64'h4004_0000_0000_0000, 1'b0, 1'b0, ZERO, UP, 1'b1, 1'b0, 1'b1);
        expect_out("R4 mem op", 64'd2, 1'b0, 1'b1, 1'b0);
        conv(64'h4004_0000_0000_0000, 1'b0, 1'b0, ZERO, UP, 1'b0, 1'b1, 1'b1);
        expect_out("R4 no enable", 64'd2, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_width;
        conv(64'h41F0_0000_0000_0000, 1'b1, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R2 2^32 wide", 64'h1_0000_0000, 1'b0, 1'b0, 1'b0);
        conv(64'h41F0_0000_0000_0000, 1'b0, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R6 2^32 narrow", ONES32, 1'b1, 1'b0, 1'b0);
        conv(64'h41F0_0000_0000_0000, 1'b1, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R3 wide ignored", ONES32, 1'b1, 1'b0, 1'b0);
        conv(64'h4004_0000_0000_0000, 1'b1, 1'b0, UP, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R3 wide ignored small", 64'd3, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_boundaries;
        conv(64'h41EF_FFFF_FFF0_0000, 1'b0, 1'b1, ZERO, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R6 2^32-0.5 zero", ONES32, 1'b0, 1'b1, 1'b0);
        conv(64'h41EF_FFFF_FFF0_0000, 1'b0, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R6 2^32-0.5 near", ONES32, 1'b1, 1'b0, 1'b0);
        conv(64'h41EF_FFFF_FFF0_0000, 1'b1, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R2 2^32-0.5 wide", 64'h1_0000_0000, 1'b0, 1'b1, 1'b0);
        conv(64'h43EF_FFFF_FFFF_FFFF, 1'b1, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R2 max wide", 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, 1'b0);
        conv(64'h43F0_0000_0000_0000, 1'b1, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R6 2^64", ONES64, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_specials;
        conv(64'h7FF8_0000_0000_0000, 1'b1, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R7 NaN", ONES64, 1'b1, 1'b0, 1'b0);
        conv(64'hFFF0_0000_0000_0000, 1'b0, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R7 -inf", ONES32, 1'b1, 1'b0, 1'b0);
        conv(64'h7FF0_0000_0000_0000, 1'b0, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R7 +inf", ONES32, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_negative;
        conv(64'hBFD3_3333_3333_3333, 1'b0, 1'b0, UP, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R8 -0.3 up", 64'd0, 1'b0, 1'b1, 1'b0);
        conv(64'hBFD3_3333_3333_3333, 1'b0, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R8 -0.3 near", 64'd0, 1'b0, 1'b1, 1'b0);
        conv(64'hBFD3_3333_3333_3333, 1'b0, 1'b0, DOWN, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R8 -0.3 down", ONES32, 1'b1, 1'b0, 1'b0);
        conv(64'hC004_0000_0000_0000, 1'b0, 1'b0, ZERO, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R8 -2.5 zero", ONES32, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_zero_denorm;
        conv(64'h0000_0000_0000_0000, 1'b1, 1'b1, UP, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R9 +0", 64'd0, 1'b0, 1'b0, 1'b0);
        conv(64'h8000_0000_0000_0000, 1'b1, 1'b1, DOWN, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R9 -0", 64'd0, 1'b0, 1'b0, 1'b0);
        conv(64'h0000_0000_0000_0001, 1'b0, 1'b0, UP, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R9 denorm up", 64'd1, 1'b0, 1'b1, 1'b0);
        conv(64'h0000_0000_0000_0001, 1'b0, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b1);
        expect_out("R9 denorm near", 64'd0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_trap;
        conv(64'h401C_0000_0000_0000, 1'b0, 1'b0, NEAR, NEAR, 1'b0, 1'b0, 1'b0);
        expect_out("R10 seed 7", 64'd7, 1'b0, 1'b0, 1'b0);
        conv(64'h7FF8_0000_0000_0000, 1'b1, 1'b1, NEAR, NEAR, 1'b0, 1'b0, 1'b0);
        expect_out("R10 trap hold", 64'd7, 1'b1, 1'b0, 1'b1);
        conv(64'h41F0_0000_0000_0000, 1'b0, 1'b1, UP, NEAR, 1'b0, 1'b0, 1'b0);
        expect_out("R10 trap ovf", 64'd7, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pipeline();
        t_round_modes();
        t_rmode_select();
        t_width();
        t_boundaries();
        t_specials();
        t_negative();
        t_zero_denorm();
        t_trap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule